// File: doc/BRIEF.md
# Double-Buffered Output Gamma Table

This block is the last tone-curve stage of a pixel pipeline. It holds two complete lookup tables, called bank A and bank B. Each bank stores, for every colour channel, a set of uniformly spaced curve points. Each point is a base value and a delta.

Each 12-bit input component is split in two. The upper bits choose a segment and the lower bits are the fraction within it. The output is the segment base plus the delta scaled by that fraction, saturated to full scale. A bypass setting passes pixels through unchanged.

Software rewrites the bank that is not in use while the other bank keeps feeding pixels. It then requests a swap, and the swap lands on the next frame-start pulse. Loading goes through a small write interface:
- a bank-select and channel-mask setting;
- a point-index load;
- one data port that takes six words per point and advances its own pointer.

A status output reports which table drives the pixels, and a hint output names the bank the next load should use.

Top module: `gamma_pingpong_lut`

## Requirements
- R1: After reset, `cfg_status` is 0 (bypass), `load_err` is 0, `out_vld` is 0 and `next_target` is 1.
- R2: The mode value and `cfg_status` use one encoding: 0 = bypass, 1 = bank A, 2 = bank B. A mode value of 3 is taken as bypass and reported as 0.
- R3: A write to the mode setting does not change `cfg_status` or the pixel path until the next `frame_start` pulse. At that pulse the pending value becomes active.
- R4: `next_target` is 1 (bank B) while the active configuration is bypass or bank A, and 0 (bank A) while bank B is active.
- R5: Consecutive accepted data words for one point are stored in this order: red base, green base, blue base, red delta, green delta, blue delta. After the sixth word the point index increments, and it wraps from the last point to point 0.
- R6: A point-index load sets the point index to the given value and restarts at the first word of that point.
- R7: `ld_mask` bit 0 enables red, bit 1 green and bit 2 blue. A word for a disabled channel is not stored, but it still advances the pointer.
- R8: While `mem_pwr_force` is 0, data words are ignored and leave the pointer unchanged.
- R9: A data word aimed at the bank that currently feeds the pixel path is dropped and leaves the pointer unchanged. It sets `load_err`, which stays set until reset.
- R10: In bank mode, segment = in[11:7] and frac = in[6:0]. The output is min(4095, base + ((delta*frac) >> 7)), registered one cycle after `pix_vld`, with `out_vld` high.
- R11: In bypass, each output component equals its input component, one cycle later.
- R12: When `frame_start` coincides with a data word or a pixel, both are handled under the configuration that was active before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_sel_wr | input | 1 | Strobe to capture bank select and channel mask |
| ld_sel_ram | input | 1 | Bank to load: 0 = A, 1 = B |
| ld_mask | input | 3 | Channel write enables (bit0 R, bit1 G, bit2 B) |
| ld_idx_wr | input | 1 | Strobe to load the point index |
| ld_idx | input | 5 | Point index value |
| ld_dat_wr | input | 1 | Data word strobe |
| ld_dat | input | 12 | Data word |
| mem_pwr_force | input | 1 | Keeps table storage powered; required for loading |
| mode_wr | input | 1 | Strobe to write the pending mode |
| mode_val | input | 2 | Pending mode value |
| frame_start | input | 1 | Frame boundary pulse that applies the pending mode |
| pix_vld | input | 1 | Input pixel valid |
| pix_r | input | 12 | Red input |
| pix_g | input | 12 | Green input |
| pix_b | input | 12 | Blue input |
| out_vld | output | 1 | Output pixel valid |
| out_r | output | 12 | Red output |
| out_g | output | 12 | Green output |
| out_b | output | 12 | Blue output |
| cfg_status | output | 2 | Active configuration |
| next_target | output | 1 | Bank the next load should use |
| load_err | output | 1 | Sticky flag for a write to the live bank |

## Verification
Two collisions are driven in a single cycle: a frame-start swap together with a data word, and a frame-start swap together with a pixel.

In the first collision, bank A is loaded while bypass is active and the swap moves to bank A. The word must land, and the pixel in that cycle must still come out as bypass. The following pixel on the same segment must then show the new base.

In the second collision, bank A is written while bank A is live and a swap to bank B is pending. That word must be rejected, which is judged later from a pixel read out of bank A.

// File: rtl/gplut_pkg.sv
package gplut_pkg;
  typedef enum logic [1:0] {
    CFG_PASS  = 2'd0,
    CFG_BANKA = 2'd1,
    CFG_BANKB = 2'd2
  } lut_cfg_e;

  localparam int NUM_CH   = 3;
  localparam int NUM_WORD = 2 * NUM_CH;

  function automatic lut_cfg_e decode_cfg(input logic [1:0] v);
    case (v)
      2'd1:    return CFG_BANKA;
      2'd2:    return CFG_BANKB;
      default: return CFG_PASS;
    endcase
  endfunction
endpackage

// File: rtl/gplut_loader.sv
module gplut_loader
  import gplut_pkg::*;
#(
  parameter int SEG_W  = 5,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic              sel_ram,
  input  logic [2:0]        sel_mask,
  input  logic              idx_wr,
  input  logic [SEG_W-1:0]  idx_val,
  input  logic              dat_wr,
  input  logic [WORD_W-1:0] dat_val,
  input  logic              pwr_force,
  input  lut_cfg_e          active,
  output logic              mem_we,
  output logic              mem_bank,
  output logic [1:0]        mem_ch,
  output logic              mem_delta,
  output logic [SEG_W-1:0]  mem_idx,
  output logic [WORD_W-1:0] mem_data,
  output logic              err
);
  localparam logic [2:0] LAST_PH = 3'(NUM_WORD - 1);

  logic              bank_q, bank_d;
  logic [2:0]        mask_q, mask_d;
  logic [2:0]        phase_q, phase_d;
  logic [SEG_W-1:0]  idx_q, idx_d;
  logic              err_q, err_d;
  logic              live_hit, accept, hit;
  logic [1:0]        ch;

  always_comb begin
    live_hit = (!bank_q && active == CFG_BANKA) || (bank_q && active == CFG_BANKB);
    accept   = dat_wr && pwr_force && !live_hit;
    hit      = dat_wr && pwr_force && live_hit;
    ch       = (phase_q >= 3'd3) ? 2'(phase_q - 3'd3) : phase_q[1:0];

    bank_d  = bank_q;
    mask_d  = mask_q;
    phase_d = phase_q;
    idx_d   = idx_q;
    err_d   = err_q | hit;
    if (sel_wr) begin
      bank_d = sel_ram;
      mask_d = sel_mask;
    end
    if (idx_wr) begin
      idx_d   = idx_val;
      phase_d = 3'd0;
    end else if (accept) begin
      if (phase_q == LAST_PH) begin
        phase_d = 3'd0;
        idx_d   = idx_q + 1'b1;
      end else begin
        phase_d = phase_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= 1'b0;
      mask_q  <= 3'b111;
      phase_q <= 3'd0;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      bank_q  <= bank_d;
      mask_q  <= mask_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  assign mem_we    = accept && mask_q[ch];
  assign mem_bank  = bank_q;
  assign mem_ch    = ch;
  assign mem_delta = (phase_q >= 3'd3);
  assign mem_idx   = idx_q;
  assign mem_data  = dat_val;
  assign err       = err_q;

  a_r9_err_on_live: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> err_q);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  a_r5_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST_PH);
  a_r8_hold_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !pwr_force && !idx_wr) |=> ($stable(phase_q) && $stable(idx_q)));
endmodule

// File: rtl/gplut_bank.sv
module gplut_bank
  import gplut_pkg::*;
#(
  parameter int SEG_W  = 5,
  parameter int WORD_W = 12
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [1:0]                     wr_ch,
  input  logic                           wr_delta,
  input  logic [SEG_W-1:0]               wr_idx,
  input  logic [WORD_W-1:0]              wr_data,
  input  logic [NUM_CH-1:0][SEG_W-1:0]   rd_seg,
  output logic [NUM_CH-1:0][WORD_W-1:0]  rd_base,
  output logic [NUM_CH-1:0][WORD_W-1:0]  rd_delta
);
  localparam int DEPTH = 1 << SEG_W;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [WORD_W-1:0] base_mem  [DEPTH];
    logic [WORD_W-1:0] delta_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wr_ch == 2'(c)) begin
        if (wr_delta) delta_mem[wr_idx] <= wr_data;
        else          base_mem[wr_idx]  <= wr_data;
      end
    end

    assign rd_base[c]  = base_mem[rd_seg[c]];
    assign rd_delta[c] = delta_mem[rd_seg[c]];
  end
endmodule

// File: rtl/gplut_eval.sv
module gplut_eval #(
  parameter int PIX_W = 12,
  parameter int SEG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             use_lut,
  input  logic [PIX_W-1:0] base,
  input  logic [PIX_W-1:0] delta,
  output logic [PIX_W-1:0] out_q
);
  localparam int FRAC_W = PIX_W - SEG_W;

  logic [FRAC_W-1:0]       frac;
  logic [PIX_W+FRAC_W-1:0] prod;
  logic [PIX_W:0]          sum;
  logic [PIX_W-1:0]        interp, out_d;

  always_comb begin
    frac   = pix_in[FRAC_W-1:0];
    prod   = delta * frac;
    sum    = {1'b0, base} + {1'b0, prod[PIX_W+FRAC_W-1:FRAC_W]};
    interp = sum[PIX_W] ? {PIX_W{1'b1}} : sum[PIX_W-1:0];
    out_d  = use_lut ? interp : pix_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (pix_vld) out_q <= out_d;
  end

  a_r11_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !use_lut) |=> (out_q == $past(pix_in)));
endmodule

// File: rtl/gamma_pingpong_lut.sv
module gamma_pingpong_lut
  import gplut_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int SEG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_sel_wr,
  input  logic             ld_sel_ram,
  input  logic [2:0]       ld_mask,
  input  logic             ld_idx_wr,
  input  logic [SEG_W-1:0] ld_idx,
  input  logic             ld_dat_wr,
  input  logic [PIX_W-1:0] ld_dat,
  input  logic             mem_pwr_force,
  input  logic             mode_wr,
  input  logic [1:0]       mode_val,
  input  logic             frame_start,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_r,
  input  logic [PIX_W-1:0] pix_g,
  input  logic [PIX_W-1:0] pix_b,
  output logic             out_vld,
  output logic [PIX_W-1:0] out_r,
  output logic [PIX_W-1:0] out_g,
  output logic [PIX_W-1:0] out_b,
  output logic [1:0]       cfg_status,
  output logic             next_target,
  output logic             load_err
);
  logic [1:0] pend_q, pend_d;
  lut_cfg_e   active_q, active_d;
  logic       vld_q;

  always_comb begin
    pend_d   = mode_wr ? mode_val : pend_q;
    active_d = frame_start ? decode_cfg(pend_q) : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 2'd0;
      active_q <= CFG_PASS;
      vld_q    <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      active_q <= active_d;
      vld_q    <= pix_vld;
    end
  end

  logic             mem_we, mem_bank, mem_delta;
  logic [1:0]       mem_ch;
  logic [SEG_W-1:0] mem_idx;
  logic [PIX_W-1:0] mem_data;

  gplut_loader #(.SEG_W(SEG_W), .WORD_W(PIX_W)) u_loader (
    .clk(clk), .rst_n(rst_n),
    .sel_wr(ld_sel_wr), .sel_ram(ld_sel_ram), .sel_mask(ld_mask),
    .idx_wr(ld_idx_wr), .idx_val(ld_idx),
    .dat_wr(ld_dat_wr), .dat_val(ld_dat),
    .pwr_force(mem_pwr_force), .active(active_q),
    .mem_we(mem_we), .mem_bank(mem_bank), .mem_ch(mem_ch),
    .mem_delta(mem_delta), .mem_idx(mem_idx), .mem_data(mem_data),
    .err(load_err)
  );

  logic [NUM_CH-1:0][PIX_W-1:0] pix_all;
  logic [NUM_CH-1:0][SEG_W-1:0] seg_all;
  logic [1:0][NUM_CH-1:0][PIX_W-1:0] bk_base, bk_delta;
  logic [NUM_CH-1:0][PIX_W-1:0] sel_base, sel_delta, out_all;
  logic use_lut, rd_bank;

  assign pix_all = {pix_b, pix_g, pix_r};
  assign use_lut = (active_q != CFG_PASS);
  assign rd_bank = (active_q == CFG_BANKB);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_seg
    assign seg_all[c] = pix_all[c][PIX_W-1 -: SEG_W];
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    gplut_bank #(.SEG_W(SEG_W), .WORD_W(PIX_W)) u_bank (
      .clk(clk),
      .we(mem_we && (mem_bank == 1'(b))),
      .wr_ch(mem_ch), .wr_delta(mem_delta), .wr_idx(mem_idx), .wr_data(mem_data),
      .rd_seg(seg_all), .rd_base(bk_base[b]), .rd_delta(bk_delta[b])
    );
  end

  assign sel_base  = bk_base[rd_bank];
  assign sel_delta = bk_delta[rd_bank];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_eval
    gplut_eval #(.PIX_W(PIX_W), .SEG_W(SEG_W)) u_eval (
      .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_in(pix_all[c]),
      .use_lut(use_lut), .base(sel_base[c]), .delta(sel_delta[c]),
      .out_q(out_all[c])
    );
  end

  assign out_r       = out_all[0];
  assign out_g       = out_all[1];
  assign out_b       = out_all[2];
  assign out_vld     = vld_q;
  assign cfg_status  = active_q;
  assign next_target = (active_q != CFG_BANKB);

  a_r3_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cfg_status));
  a_r2_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_status != 2'd3);
  a_r10_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> out_vld);
  a_r4_hint_match: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_status == 2'd2) |-> !next_target);
endmodule

// File: tb/gamma_pingpong_lut_tb.sv
module gamma_pingpong_lut_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_sel_wr = 0, ld_sel_ram = 0, ld_idx_wr = 0, ld_dat_wr = 0;
  logic [2:0] ld_mask = 3'b111;
  logic [4:0] ld_idx = 0;
  logic [11:0] ld_dat = 0;
  logic mem_pwr_force = 0, mode_wr = 0, frame_start = 0, pix_vld = 0;
  logic [1:0] mode_val = 0;
  logic [11:0] pix_r = 0, pix_g = 0, pix_b = 0;
  logic out_vld, next_target, load_err;
  logic [11:0] out_r, out_g, out_b;
  logic [1:0] cfg_status;

  always #4 clk = ~clk;

  gamma_pingpong_lut u_dut (
    .clk(clk), .rst_n(rst_n), .ld_sel_wr(ld_sel_wr), .ld_sel_ram(ld_sel_ram),
    .ld_mask(ld_mask), .ld_idx_wr(ld_idx_wr), .ld_idx(ld_idx),
    .ld_dat_wr(ld_dat_wr), .ld_dat(ld_dat), .mem_pwr_force(mem_pwr_force),
    .mode_wr(mode_wr), .mode_val(mode_val), .frame_start(frame_start),
    .pix_vld(pix_vld), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_vld(out_vld), .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .cfg_status(cfg_status), .next_target(next_target), .load_err(load_err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int mb [2][3][32];
  int md [2][3][32];
  int m_sel = 0, m_mask = 7, m_phase = 0, m_idx = 0, m_pend = 0, m_act = 0, m_err = 0;

  logic [35:0] exp_q [$];
  string       tag_q [$];

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_chan(int c, int v);
    int bk, seg, frac, s;
    if (m_act == 0) return v;
    bk   = m_act - 1;
    seg  = (v >> 7) & 31;
    frac = v & 127;
    s    = mb[bk][c][seg] + ((md[bk][c][seg] * frac) >> 7);
    return (s > 4095) ? 4095 : s;
  endfunction

  function automatic void model_word(int d);
    int c;
    if (mem_pwr_force == 1'b0) return;
    if ((m_sel == 0 && m_act == 1) || (m_sel == 1 && m_act == 2)) begin
      m_err = 1;
      return;
    end
    c = m_phase % 3;
    if (m_mask[c]) begin
      if (m_phase < 3) mb[m_sel][c][m_idx] = d;
      else             md[m_sel][c][m_idx] = d;
    end
    if (m_phase == 5) begin
      m_phase = 0;
      m_idx = (m_idx + 1) % 32;
    end else m_phase++;
  endfunction

  function automatic void model_frame();
    m_act = (m_pend <= 2) ? m_pend : 0;
  endfunction

  function automatic void push_pix(string tag, int r, int g, int b);
    exp_q.push_back({12'(exp_chan(2, b)), 12'(exp_chan(1, g)), 12'(exp_chan(0, r))});
    tag_q.push_back(tag);
  endfunction

  task automatic set_sel(int ram, int mask);
    @(negedge clk);
    ld_sel_wr = 1; ld_sel_ram = 1'(ram); ld_mask = 3'(mask);
    m_sel = ram; m_mask = mask;
    @(posedge clk); #1 ld_sel_wr = 0;
  endtask

  task automatic set_idx(int i);
    @(negedge clk);
    ld_idx_wr = 1; ld_idx = 5'(i);
    m_idx = i; m_phase = 0;
    @(posedge clk); #1 ld_idx_wr = 0;
  endtask

  task automatic put_word(int d);
    @(negedge clk);
    ld_dat_wr = 1; ld_dat = 12'(d);
    model_word(d);
    @(posedge clk); #1 ld_dat_wr = 0;
  endtask

  task automatic set_mode(int m);
    @(negedge clk);
    mode_wr = 1; mode_val = 2'(m);
    m_pend = m;
    @(posedge clk); #1 mode_wr = 0;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1;
    @(posedge clk); #1 frame_start = 0;
    model_frame();
  endtask

  task automatic send_pix(string tag, int r, int g, int b);
    @(negedge clk);
    pix_vld = 1; pix_r = 12'(r); pix_g = 12'(g); pix_b = 12'(b);
    push_pix(tag, r, g, b);
    @(posedge clk); #1 pix_vld = 0;
  endtask

  // same-cycle frame swap, data word and pixel (R12)
  task automatic collide(int d, int r, int g, int b);
    @(negedge clk);
    frame_start = 1; ld_dat_wr = 1; ld_dat = 12'(d);
    pix_vld = 1; pix_r = 12'(r); pix_g = 12'(g); pix_b = 12'(b);
    push_pix("R12 pixel at swap", r, g, b);
    model_word(d);
    model_frame();
    @(posedge clk); #1 frame_start = 0; ld_dat_wr = 0; pix_vld = 0;
  endtask

  task automatic load_point(int b0, int b1, int b2, int d0, int d1, int d2);
    put_word(b0); put_word(b1); put_word(b2);
    put_word(d0); put_word(d1); put_word(d2);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10 unexpected output actual=%0d expected=none", out_r);
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " red"},   int'(out_r), int'(e[11:0]));
        check({t, " green"}, int'(out_g), int'(e[23:12]));
        check({t, " blue"},  int'(out_b), int'(e[35:24]));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 cfg_status", int'(cfg_status), 0);
    check("R1 load_err", int'(load_err), 0);
    check("R1 out_vld", int'(out_vld), 0);
    check("R1 next_target", int'(next_target), 1);

    // R11 bypass
    send_pix("R11 bypass", 12'h000, 12'hfff, 12'h5a3);
    send_pix("R11 bypass", 12'h123, 12'h800, 12'h07f);
    drain();

    // load both banks fully (R5 order, R6 index restart)
    mem_pwr_force = 1;
    for (int bk = 0; bk < 2; bk++) begin
      set_sel(bk, 7);
      set_idx(0);
      for (int p = 0; p < 32; p++) begin
        if (p == 31 && bk == 1)
          load_point(4000, 100 * bk + 50, 3000, 4095, 64, 0);
        else
          load_point((p * 120 + bk * 33) % 4096, (p * 97 + 11) % 4096,
                     (p * 61 + bk * 500) % 4096, (p * 13 + 40 * bk) % 4096,
                     (p * 7 + 300) % 4096, (255 - p * 3 + bk) % 4096);
      end
    end

    // R3 mode pending until frame start
    set_mode(2);
    check("R3 status before frame", int'(cfg_status), 0);
    send_pix("R3 still bypass", 12'h345, 12'h678, 12'h9ab);
    drain();
    pulse_frame();
    @(negedge clk);
    check("R2 status bank B", int'(cfg_status), 2);
    check("R4 next target A", int'(next_target), 0);
    // R10 interpolation and saturation
    send_pix("R10 bank B", 12'h000, 12'h0ff, 12'h3c0);
    send_pix("R10 bank B", 12'h5a5, 12'habc, 12'h7ff);
    send_pix("R10 saturate", 12'hfff, 12'hf80, 12'hfc0);
    drain();

    // R9 write to live bank
    set_sel(1, 7);
    set_idx(3);
    put_word(12'hfff);
    @(negedge clk);
    check("R9 load_err set", int'(load_err), 1);
    send_pix("R9 live bank untouched", 12'h1c0, 12'h1c0, 12'h1c0);
    drain();

    // R7 mask green only, bank A
    set_sel(0, 2);
    set_idx(4);
    load_point(11, 22, 33, 44, 55, 66);
    set_mode(1);
    pulse_frame();
    @(negedge clk);
    check("R2 status bank A", int'(cfg_status), 1);
    check("R4 next target B", int'(next_target), 1);
    send_pix("R7 mask green", 12'h240, 12'h240, 12'h27f);
    drain();

    // R8 power override low: words ignored, pointer held
    mem_pwr_force = 0;
    set_sel(1, 7);
    set_idx(6);
    put_word(1); put_word(2); put_word(3);
    mem_pwr_force = 1;
    load_point(100, 200, 300, 400, 500, 600);
    set_mode(2);
    pulse_frame();
    send_pix("R8 pointer held", 12'h340, 12'h37f, 12'h310);
    drain();

    // R5 wrap from last point to 0, bank A
    set_sel(0, 7);
    set_idx(31);
    load_point(3900, 10, 20, 30, 40, 50);
    load_point(7, 8, 9, 128, 256, 512);
    set_mode(1);
    pulse_frame();
    send_pix("R5 last point", 12'hf80, 12'hfc0, 12'hfff);
    send_pix("R5 wrapped to 0", 12'h040, 12'h07f, 12'h001);
    drain();

    // R2 illegal mode -> bypass
    set_mode(3);
    pulse_frame();
    @(negedge clk);
    check("R2 mode 3 status", int'(cfg_status), 0);
    check("R4 next target after bypass", int'(next_target), 1);
    send_pix("R2 mode 3 bypass", 12'h111, 12'h222, 12'h333);
    drain();

    // R12 collisions
    set_mode(1);
    set_sel(0, 7);
    set_idx(10);
    collide(2222, 12'h500, 12'h520, 12'h540);
    send_pix("R12 word landed", 12'h500, 12'h500, 12'h500);
    drain();
    set_mode(2);
    set_idx(12);
    collide(999, 12'h600, 12'h600, 12'h600);
    mem_pwr_force = 1;
    set_mode(1);
    pulse_frame();
    send_pix("R12 word rejected", 12'h600, 12'h610, 12'h620);
    drain();
    @(negedge clk);
    check("R9 load_err sticky", int'(load_err), 1);
    check("R10 queue drained", exp_q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule